// File: doc/BRIEF.md
# Lookahead Handshake Pipeline Buffer

This block sits between a producer built from combinational logic and a consumer that expects registered data. On the producer side the buffer drives `next_take`, a prediction that it will have room for a word in the following enabled cycle. The producer registers that flag and returns it on `in_take`. A word is captured in any enabled cycle where `in_take` and `in_valid` are both high. Because of this one-cycle feedback loop, the producer may count on a transfer in the next step whenever either `next_take` or `in_take` is high.

On the consumer side the buffer presents a registered word on `out_data` with `out_valid`. The word leaves in an enabled cycle where `out_valid` and `out_ready` are both high. The `MODE` parameter selects the variant. `MODE`=0 holds two words and sustains one word per cycle. `MODE`=1 holds a single word and refuses further input until that word has been taken, which gives at most half rate. Reset is synchronous and active low, and every state update waits for `clk_en`.

Top module: `hsbuf_lookahead`

## Requirements
- R1: In the first cycle after a reset cycle (`rst_n` low at a clock edge), `out_valid`=0, `occupied`=0 and `next_take`=1. This holds whatever the buffer held before the reset.
- R2: A word is captured in an enabled cycle where `in_take`=1 and `in_valid`=1. Captured words appear on `out_data` in capture order, with no word lost or repeated.
- R3: `out_valid` is high exactly when the buffer holds a word. The head word is removed in an enabled cycle where `out_valid`=1 and `out_ready`=1.
- R4: Let the held count be c, let cap be 1 for a capture this cycle, and let pop be 1 for a removal this cycle. `next_take` equals (c + cap − pop) < S, where S is 2 for `MODE`=0 and 1 for `MODE`=1. As a result, a word offered on the fed-back `in_take` always finds room.
- R5: In `MODE`=0, with `in_valid` and `out_ready` held high, the buffer captures one word in every cycle once it reaches steady state.
- R6: In `MODE`=1, `next_take` is low in any cycle that captures a word. With `in_valid` and `out_ready` held high, the buffer captures one word every two cycles.
- R7: While `clk_en`=0, nothing is captured or removed, and the held words and outputs stay unchanged.
- R8: `occupied` is high whenever at least one word is held.
- R9: In `MODE`=0, with the output stalled, the buffer fills to two words and `next_take` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable for all state updates |
| in_valid | input | 1 | Producer offers a word |
| in_data | input | DATA_W | Producer word |
| in_take | input | 1 | Producer's registered copy of next_take |
| next_take | output | 1 | Room for a word in the next enabled cycle |
| out_valid | output | 1 | Registered head word is valid |
| out_data | output | DATA_W | Registered head word |
| out_ready | input | 1 | Consumer takes the head word |
| occupied | output | 1 | At least one word held |

## Verification
Both variants run side by side. The bench sweeps every 4-cycle pattern of `in_valid` against every 4-cycle pattern of `out_ready`, under both a steady and a gapped `clk_en`. It checks cycle by cycle against an arithmetic occupancy model and a sequence-number model of the data. Steady streaming separates the full-rate variant from the half-rate one. A stalled output shows whether the predictive flag drops in time to avoid overflow. A reset issued while the buffer holds words shows whether reset really clears it.

// File: rtl/hsbuf_pkg.sv
package hsbuf_pkg;
  // Number of storage stages implied by the operating mode.
  function automatic int stages_for(input int mode);
    return (mode == 0) ? 2 : 1;
  endfunction
endpackage

// File: rtl/hsbuf_occupancy.sv
module hsbuf_occupancy #(
  parameter int DEPTH = 2,
  parameter int MODE  = 0,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          in_valid,
  input  logic          in_take,
  input  logic          out_ready,
  output logic          cap,
  output logic          rd,
  output logic [CW-1:0] count,
  output logic          out_valid,
  output logic          next_take
);
  localparam logic [CW:0] DEPTH_V = (CW + 1)'(DEPTH);

  logic [CW:0]   proj;
  logic [CW-1:0] count_nx;

  always_comb begin
    out_valid = (count != '0);
    cap       = clk_en & in_take & in_valid;
    rd        = clk_en & out_ready & out_valid;
    proj      = (CW + 1)'(count) + (CW + 1)'(cap) - (CW + 1)'(rd);
    count_nx  = proj[CW-1:0];
    next_take = (proj < DEPTH_V);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clk_en) begin
      count <= count_nx;
    end else begin
      count <= count;
    end
  end

  // R4: a capture that is not offset by a removal must find a free stage
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !rd) |-> (count < DEPTH_V[CW-1:0]));

  // R7: a disabled cycle leaves the occupancy untouched
  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && rst_n) |=> $stable(count));

  // R1: a reset cycle empties the buffer
  assert_reset_empty_R1: assert property (@(posedge clk)
    (rst_n === 1'b0) |=> (count == '0));

  // R3: an unread head word stays valid
  assert_head_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !rd && rst_n) |=> out_valid);

  generate
    if (MODE == 1) begin : g_half
      // R6: capturing a word withdraws the next-cycle offer
      assert_half_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> !next_take);
    end
  endgenerate
endmodule

// File: rtl/hsbuf_stage_array.sv
module hsbuf_stage_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              wr,
  input  logic              rd,
  input  logic [CW-1:0]     count,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head
);
  logic [DATA_W-1:0] stage    [DEPTH];
  logic [DATA_W-1:0] stage_nx [DEPTH];
  logic [CW-1:0]     widx;

  assign widx = count - CW'(rd);
  assign head = stage[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [DATA_W-1:0] shifted;
    if (i + 1 < DEPTH) begin : g_mid
      assign shifted = rd ? stage[i+1] : stage[i];
    end else begin : g_last
      assign shifted = stage[i];
    end

    always_comb begin
      stage_nx[i] = shifted;
      if (wr && (widx == CW'(i))) stage_nx[i] = din;
    end

    always_ff @(posedge clk) begin
      if (clk_en) stage[i] <= stage_nx[i];
      else        stage[i] <= stage[i];
    end
  end

  // R2: a word written into an empty slot becomes the head next cycle
  assert_capture_to_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (widx == '0)) |=> (head == $past(din)));

  generate
    if (DEPTH > 1) begin : g_order
      // R2: removing the head promotes the second word unchanged
      assert_promote_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (count == CW'(2))) |=> (head == $past(stage[1])));
    end
  endgenerate
endmodule

// File: rtl/hsbuf_lookahead.sv
module hsbuf_lookahead #(
  parameter int DATA_W = 8,
  parameter int MODE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_take,
  output logic              next_take,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              occupied
);
  localparam int DEPTH = hsbuf_pkg::stages_for(MODE);
  localparam int CW    = $clog2(DEPTH + 1);

  logic          cap;
  logic          rd;
  logic [CW-1:0] count;

  hsbuf_occupancy #(.DEPTH(DEPTH), .MODE(MODE)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .in_valid  (in_valid),
    .in_take   (in_take),
    .out_ready (out_ready),
    .cap       (cap),
    .rd        (rd),
    .count     (count),
    .out_valid (out_valid),
    .next_take (next_take)
  );

  hsbuf_stage_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stages (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .wr     (cap),
    .rd     (rd),
    .count  (count),
    .din    (in_data),
    .head   (out_data)
  );

  assign occupied = (count != '0);

  // R8: the status flag agrees with the presented head word
  assert_status_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occupied == out_valid);
endmodule

// File: tb/tb_hsbuf_lookahead.sv
module tb_hsbuf_lookahead;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, en;
  logic       iv [2];
  logic [7:0] id [2];
  logic       take_q [2];
  logic       nt [2];
  logic       ov [2];
  logic [7:0] od [2];
  logic       ordy [2];
  logic       occ [2];

  int checks = 0, fails = 0;
  int cnt [2], wseq [2], rseq [2], wincap [2];
  int dep [2] = '{2, 1};
  bit win = 0, done = 0;

  hsbuf_lookahead #(.DATA_W(8), .MODE(0)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(en), .in_valid(iv[0]), .in_data(id[0]),
    .in_take(take_q[0]), .next_take(nt[0]), .out_valid(ov[0]), .out_data(od[0]),
    .out_ready(ordy[0]), .occupied(occ[0]));

  hsbuf_lookahead #(.DATA_W(8), .MODE(1)) dut_half (
    .clk(clk), .rst_n(rst_n), .clk_en(en), .in_valid(iv[1]), .in_data(id[1]),
    .in_take(take_q[1]), .next_take(nt[1]), .out_valid(ov[1]), .out_data(od[1]),
    .out_ready(ordy[1]), .occupied(occ[1]));

  function automatic logic [7:0] pat(input int s);
    return 8'((s * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit r, input bit e);
    int  capk [2];
    int  popk [2];
    bit  expnt [2];
    @(negedge clk);
    en = e;
    for (int k = 0; k < 2; k++) begin
      iv[k] = v; id[k] = pat(wseq[k]); ordy[k] = r;
    end
    #1;
    for (int k = 0; k < 2; k++) begin
      chk(ov[k] == (cnt[k] != 0), e ? "R3 out_valid" : "R7 out_valid", int'(ov[k]), int'(cnt[k] != 0));
      chk(occ[k] == (cnt[k] != 0), "R8 occupied", int'(occ[k]), int'(cnt[k] != 0));
      if (cnt[k] != 0)
        chk(od[k] == pat(rseq[k]), e ? "R2 data order" : "R7 data held", int'(od[k]), int'(pat(rseq[k])));
      capk[k]  = (e && take_q[k] && v) ? 1 : 0;
      popk[k]  = (e && cnt[k] != 0 && r) ? 1 : 0;
      expnt[k] = (cnt[k] + capk[k] - popk[k]) < dep[k];
      chk(nt[k] == expnt[k], "R4 next_take", int'(nt[k]), int'(expnt[k]));
      if (k == 1 && capk[k] == 1) chk(nt[k] == 1'b0, "R6 block after capture", int'(nt[k]), 0);
    end
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      take_q[k] <= e ? expnt[k] : take_q[k];
      cnt[k]  += capk[k] - popk[k];
      wseq[k] += capk[k];
      rseq[k] += popk[k];
      if (win) wincap[k] += capk[k];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b1;
    for (int k = 0; k < 2; k++) begin iv[k] = 1'b0; ordy[k] = 1'b0; end
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      take_q[k] <= 1'b0; cnt[k] = 0; rseq[k] = wseq[k];
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int k = 0; k < 2; k++) begin
      chk(ov[k] == 1'b0, "R1 out_valid after reset", int'(ov[k]), 0);
      chk(occ[k] == 1'b0, "R1 occupied after reset", int'(occ[k]), 0);
      chk(nt[k] == 1'b1, "R1 next_take after reset", int'(nt[k]), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      iv[k] = 1'b0; id[k] = '0; ordy[k] = 1'b0; take_q[k] = 1'b0;
      cnt[k] = 0; wseq[k] = 0; rseq[k] = 0; wincap[k] = 0;
    end
    do_reset();

    // near-exhaustive sweep of 4-cycle valid and ready patterns (R2, R3, R4, R7)
    for (int em = 0; em < 2; em++)
      for (int vm = 0; vm < 16; vm++)
        for (int rm = 0; rm < 16; rm++)
          for (int c = 0; c < 8; c++)
            step(vm[c % 4], rm[c % 4], (em == 0) ? 1'b1 : ((c % 3) != 1));

    // steady streaming throughput (R5, R6)
    do_reset();
    for (int c = 0; c < 10; c++) step(1'b1, 1'b1, 1'b1);
    win = 1;
    for (int c = 0; c < 30; c++) step(1'b1, 1'b1, 1'b1);
    win = 0;
    chk(wincap[0] == 30, "R5 full-rate captures", wincap[0], 30);
    chk(wincap[1] == 15, "R6 half-rate captures", wincap[1], 15);

    // stalled output: fill, then check the prediction (R9, R6)
    for (int c = 0; c < 6; c++) step(1'b1, 1'b0, 1'b1);
    @(negedge clk); #1;
    chk(nt[0] == 1'b0, "R9 next_take low when full", int'(nt[0]), 0);
    chk(nt[1] == 1'b0, "R6 next_take low while held", int'(nt[1]), 0);
    chk(cnt[0] == 2, "R9 two words held", cnt[0], 2);
    for (int c = 0; c < 6; c++) step(1'b0, 1'b1, 1'b1);

    // reset with words held (R1)
    for (int c = 0; c < 4; c++) step(1'b1, 1'b0, 1'b1);
    do_reset();
    for (int c = 0; c < 8; c++) step(1'b1, 1'b1, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule